// File: doc/BRIEF.md
# Memory-Test Address Sequencer with Ping-Pong Inversion

This block produces the stream of bank, row and column addresses that a built-in DRAM self-test engine walks through. A test sequencer configures it, pulses `start`, and then takes one address per `advance` strobe. It steps three nested field counters (bank, row, column) in one of four orders. Each field runs over its full binary range or between a programmed low and high value. Traversal runs upward from the low corner or downward from the high corner.

An optional ping-pong inversion mode raises switching on the address lines. The counters keep stepping as usual, but every second issued address takes the bitwise complement of the address issued just before it. The exception is the lowest column bit, which always carries the counter's own value. Inverted accesses are not clipped to the programmed range, so they may land outside it and may hit a bank other than the fixed one. A bank-change flag marks every access whose bank differs from the previous access, so the command logic can close the old bank and open the new one.

The output side follows valid/ready rules. `addr_valid` plays valid and `advance` plays ready. An address is consumed on a cycle where both are high. While `advance` is low the presented address and flags hold unchanged, so the sequencer can stall for as long as it needs. Configuration is sampled on the `start` cycle, and a `start` during a run restarts it.

Top module: `bist_addr_gen`

## Requirements
- R1: The cycle after `start` is high, `addr_valid` is 1 and `done` is 0. The address shown is the first address of the configured walk. When `start` and `advance` are both high, `start` wins.
- R2: While `addr_valid` is 1 and `advance` is 0 (and no `start`), the address fields and `bank_change` hold from cycle to cycle.
- R3: With `cfg_range`=0 (full addressing), each stepping field spans 0 to its all-ones value. In the fixed-bank orders the bank is 0.
- R4: With `cfg_range`=1, each stepping field spans from its start field to its end field, with start ≤ end assumed per field. In the fixed-bank orders the bank equals `cfg_start_bank`.
- R5: `cfg_mode` picks the nesting, fastest field first. 0: column, then row, bank fixed. 1: row, then column, bank fixed. 2: column, then bank, then row. 3: row, then bank, then column. A field steps when every faster field is at its terminal value, and it then wraps.
- R6: With `cfg_down`=0 each field starts at its low value and counts up. With `cfg_down`=1 each field starts at its high value and counts down.
- R7: With `cfg_invert`=1, access k of a run is numbered from 0. For odd k, bits above the LSB of the concatenation {bank,row,col} are the complement of the same bits of access k-1. The LSB (`addr_col[0]`) equals bit 0 of the counter value for access k. These accesses are not limited to the range.
- R8: With `cfg_invert`=0, every access is the plain counter value.
- R9: Access 0 after every `start` is non-inverted.
- R10: `bank_change` is 1 with access 0 of a run. On any later access it is 1 exactly when the issued bank differs from the previously issued bank.
- R11: When the final counter value is consumed, the next cycle has `addr_valid`=0 and `done`=1. `done` stays 1 until the next `start`, and `addr_valid` and `done` are never both 1.
- R12: A `start` while a run is in progress abandons that run and begins the new one per R1.
- R13: During reset and after it until the first `start`, `addr_valid`, `done` and `bank_change` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Sequencing order (R5) |
| cfg_range | input | 1 | 1: range addressing, 0: full addressing |
| cfg_down | input | 1 | 1: decrementing traversal |
| cfg_invert | input | 1 | 1: ping-pong inversion enabled |
| cfg_start_bank | input | BANK_W | Range low bank / fixed bank |
| cfg_start_row | input | ROW_W | Range low row |
| cfg_start_col | input | COL_W | Range low column |
| cfg_end_bank | input | BANK_W | Range high bank |
| cfg_end_row | input | ROW_W | Range high row |
| cfg_end_col | input | COL_W | Range high column |
| start | input | 1 | Begin (or restart) a walk, sampling configuration |
| advance | input | 1 | Ready: consume the presented address |
| addr_bank | output | BANK_W | Issued bank |
| addr_row | output | ROW_W | Issued row |
| addr_col | output | COL_W | Issued column |
| addr_valid | output | 1 | Address presented |
| bank_change | output | 1 | Issued bank differs from the previous access |
| done | output | 1 | Walk complete |

## Verification
The checker assumes that configuration inputs only matter on the `start` cycle. It also assumes that per-field start values never exceed end values under range addressing, since a reversed range has no defined walk. The bench changes configuration only together with a `start` pulse and picks start/end pairs in order. It drives `advance` with a random duty so that stalls of varied length occur, and it raises `start` mid-walk once to cover the restart path.

// File: rtl/bist_ag_pkg.sv
package bist_ag_pkg;
  typedef enum logic [1:0] {
    SEQ_COL_ROW      = 2'd0,
    SEQ_ROW_COL      = 2'd1,
    SEQ_COL_BANK_ROW = 2'd2,
    SEQ_ROW_BANK_COL = 2'd3
  } seq_e;
endpackage

// File: rtl/bist_ag_digit.sv
// One wrapping field counter between a low and a high bound.
module bist_ag_digit #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         step,
  input  logic         down,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] val,
  output logic         at_end
);
  assign at_end = down ? (val == lo) : (val == hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else if (load) begin
      val <= init;
    end else if (step) begin
      if (at_end) val <= down ? hi : lo;
      else        val <= down ? val - W'(1) : val + W'(1);
    end
  end
endmodule

// File: rtl/bist_ag_seq.sv
// Three nested field counters whose carry order is chosen by the mode.
module bist_ag_seq import bist_ag_pkg::*; #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  seq_e              mode,
  input  logic              down,
  input  logic [BANK_W-1:0] b_lo, b_hi, b_init,
  input  logic [ROW_W-1:0]  r_lo, r_hi, r_init,
  input  logic [COL_W-1:0]  c_lo, c_hi, c_init,
  output logic [BANK_W-1:0] b_val,
  output logic [ROW_W-1:0]  r_val,
  output logic [COL_W-1:0]  c_val,
  output logic              last
);
  logic b_end, r_end, c_end;
  logic b_step, r_step, c_step;

  always_comb begin
    unique case (mode)
      SEQ_COL_ROW: begin
        c_step = adv;
        r_step = adv & c_end;
        b_step = adv & c_end & r_end;
      end
      SEQ_ROW_COL: begin
        r_step = adv;
        c_step = adv & r_end;
        b_step = adv & r_end & c_end;
      end
      SEQ_COL_BANK_ROW: begin
        c_step = adv;
        b_step = adv & c_end;
        r_step = adv & c_end & b_end;
      end
      default: begin
        r_step = adv;
        b_step = adv & r_end;
        c_step = adv & r_end & b_end;
      end
    endcase
  end

  assign last = b_end & r_end & c_end;

  bist_ag_digit #(.W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load), .init(b_init), .step(b_step),
    .down(down), .lo(b_lo), .hi(b_hi), .val(b_val), .at_end(b_end));
  bist_ag_digit #(.W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load(load), .init(r_init), .step(r_step),
    .down(down), .lo(r_lo), .hi(r_hi), .val(r_val), .at_end(r_end));
  bist_ag_digit #(.W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(load), .init(c_init), .step(c_step),
    .down(down), .lo(c_lo), .hi(c_hi), .val(c_val), .at_end(c_end));
endmodule

// File: rtl/bist_ag_invert.sv
// Ping-pong stage: odd accesses complement the previous issue above the LSB.
module bist_ag_invert #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          accept,
  input  logic          inv_en,
  input  logic [AW-1:0] cnt,
  output logic [AW-1:0] issued
);
  logic          phase;
  logic [AW-2:0] prev_hi;

  assign issued = phase ? {~prev_hi, cnt[0]} : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      prev_hi <= '0;
    end else if (start) begin
      phase   <= 1'b0;
    end else if (accept) begin
      phase   <= inv_en ? ~phase : 1'b0;
      prev_hi <= issued[AW-1:1];
    end
  end
endmodule

// File: rtl/bist_addr_gen.sv
module bist_addr_gen import bist_ag_pkg::*; #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_range,
  input  logic              cfg_down,
  input  logic              cfg_invert,
  input  logic [BANK_W-1:0] cfg_start_bank,
  input  logic [ROW_W-1:0]  cfg_start_row,
  input  logic [COL_W-1:0]  cfg_start_col,
  input  logic [BANK_W-1:0] cfg_end_bank,
  input  logic [ROW_W-1:0]  cfg_end_row,
  input  logic [COL_W-1:0]  cfg_end_col,
  input  logic              start,
  input  logic              advance,
  output logic [BANK_W-1:0] addr_bank,
  output logic [ROW_W-1:0]  addr_row,
  output logic [COL_W-1:0]  addr_col,
  output logic              addr_valid,
  output logic              bank_change,
  output logic              done
);
  localparam int AW = BANK_W + ROW_W + COL_W;

  seq_e              mode_raw, mode_q;
  logic              down_q, inv_q;
  logic              fixed_bank;
  logic [BANK_W-1:0] b_lo_raw, b_hi_raw, b_lo_q, b_hi_q, b_init;
  logic [ROW_W-1:0]  r_lo_raw, r_hi_raw, r_lo_q, r_hi_q, r_init;
  logic [COL_W-1:0]  c_lo_raw, c_hi_raw, c_lo_q, c_hi_q, c_init;
  logic [BANK_W-1:0] b_cnt;
  logic [ROW_W-1:0]  r_cnt;
  logic [COL_W-1:0]  c_cnt;
  logic [AW-1:0]     issued;
  logic              last, accept;
  logic              first_q;
  logic [BANK_W-1:0] prev_bank;

  assign mode_raw   = seq_e'(cfg_mode);
  assign fixed_bank = (mode_raw == SEQ_COL_ROW) || (mode_raw == SEQ_ROW_COL);
  assign accept     = addr_valid & advance & ~start;

  // Bounds from the raw configuration, used on the start cycle.
  always_comb begin
    if (cfg_range) begin
      b_lo_raw = cfg_start_bank; b_hi_raw = cfg_end_bank;
      r_lo_raw = cfg_start_row;  r_hi_raw = cfg_end_row;
      c_lo_raw = cfg_start_col;  c_hi_raw = cfg_end_col;
    end else begin
      b_lo_raw = '0; b_hi_raw = '1;
      r_lo_raw = '0; r_hi_raw = '1;
      c_lo_raw = '0; c_hi_raw = '1;
    end
    if (fixed_bank) begin
      b_lo_raw = cfg_range ? cfg_start_bank : '0;
      b_hi_raw = b_lo_raw;
    end
  end

  assign b_init = cfg_down ? b_hi_raw : b_lo_raw;
  assign r_init = cfg_down ? r_hi_raw : r_lo_raw;
  assign c_init = cfg_down ? c_hi_raw : c_lo_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= SEQ_COL_ROW;
      down_q <= 1'b0;
      inv_q  <= 1'b0;
      b_lo_q <= '0; b_hi_q <= '0;
      r_lo_q <= '0; r_hi_q <= '0;
      c_lo_q <= '0; c_hi_q <= '0;
    end else if (start) begin
      mode_q <= mode_raw;
      down_q <= cfg_down;
      inv_q  <= cfg_invert;
      b_lo_q <= b_lo_raw; b_hi_q <= b_hi_raw;
      r_lo_q <= r_lo_raw; r_hi_q <= r_hi_raw;
      c_lo_q <= c_lo_raw; c_hi_q <= c_hi_raw;
    end
  end

  bist_ag_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(start), .adv(accept),
    .mode(mode_q), .down(down_q),
    .b_lo(b_lo_q), .b_hi(b_hi_q), .b_init(b_init),
    .r_lo(r_lo_q), .r_hi(r_hi_q), .r_init(r_init),
    .c_lo(c_lo_q), .c_hi(c_hi_q), .c_init(c_init),
    .b_val(b_cnt), .r_val(r_cnt), .c_val(c_cnt), .last(last));

  bist_ag_invert #(.AW(AW)) u_inv (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .inv_en(inv_q), .cnt({b_cnt, r_cnt, c_cnt}), .issued(issued));

  assign addr_bank = issued[AW-1 -: BANK_W];
  assign addr_row  = issued[COL_W +: ROW_W];
  assign addr_col  = issued[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      done       <= 1'b0;
      first_q    <= 1'b0;
      prev_bank  <= '0;
    end else if (start) begin
      addr_valid <= 1'b1;
      done       <= 1'b0;
      first_q    <= 1'b1;
    end else if (accept) begin
      first_q   <= 1'b0;
      prev_bank <= addr_bank;
      if (last) begin
        addr_valid <= 1'b0;
        done       <= 1'b1;
      end
    end
  end

  assign bank_change = addr_valid & (first_q | (addr_bank != prev_bank));
endmodule

// File: rtl/bist_addr_gen_chk.sv
module bist_addr_gen_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_invert,
  input logic              start,
  input logic              advance,
  input logic [BANK_W-1:0] addr_bank,
  input logic [ROW_W-1:0]  addr_row,
  input logic [COL_W-1:0]  addr_col,
  input logic              addr_valid,
  input logic              bank_change,
  input logic              done
);
  localparam int AW = BANK_W + ROW_W + COL_W;

  logic [AW-1:0]     a_cat;
  logic              c_ph, c_inv, c_first;
  logic [AW-2:0]     c_prev_hi;
  logic [BANK_W-1:0] c_prev_bank;

  assign a_cat = {addr_bank, addr_row, addr_col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ph <= 1'b0; c_inv <= 1'b0; c_first <= 1'b0;
      c_prev_hi <= '0; c_prev_bank <= '0;
    end else if (start) begin
      c_ph <= 1'b0; c_inv <= cfg_invert; c_first <= 1'b1;
    end else if (addr_valid && advance) begin
      c_ph        <= ~c_ph;
      c_first     <= 1'b0;
      c_prev_hi   <= a_cat[AW-1:1];
      c_prev_bank <= addr_bank;
    end
  end

  AST_START_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_valid && !done); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !advance && !start |=> $stable(a_cat) && $stable(bank_change)); // R2
  AST_PING_PONG: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && c_inv && c_ph |-> a_cat[AW-1:1] == ~c_prev_hi); // R7
  AST_BANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> bank_change == (c_first || addr_bank != c_prev_bank)); // R10
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && done)); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R11
endmodule

bind bist_addr_gen bist_addr_gen_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_invert(cfg_invert), .start(start), .advance(advance),
  .addr_bank(addr_bank), .addr_row(addr_row), .addr_col(addr_col),
  .addr_valid(addr_valid), .bank_change(bank_change), .done(done));

// File: tb/bist_addr_gen_test.sv
module bist_addr_gen_test;
  localparam int BW = 2, RW = 3, CW = 3;
  localparam int AW = BW + RW + CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic cfg_range = 0, cfg_down = 0, cfg_invert = 0;
  logic [BW-1:0] sb = '0, eb = '0;
  logic [RW-1:0] sr = '0, er = '0;
  logic [CW-1:0] sc = '0, ec = '0;
  logic start = 0, advance = 0;
  logic [BW-1:0] addr_bank;
  logic [RW-1:0] addr_row;
  logic [CW-1:0] addr_col;
  logic addr_valid, bank_change, done;

  int checks = 0, errors = 0, cycles = 0;

  logic [AW-1:0] exp_q[$];
  bit            bc_q[$];
  bit            ev = 0, ed = 0;
  int            idx = 0;

  always #5 clk = ~clk;

  bist_addr_gen #(.BANK_W(BW), .ROW_W(RW), .COL_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_range(cfg_range),
    .cfg_down(cfg_down), .cfg_invert(cfg_invert),
    .cfg_start_bank(sb), .cfg_start_row(sr), .cfg_start_col(sc),
    .cfg_end_bank(eb), .cfg_end_row(er), .cfg_end_col(ec),
    .start(start), .advance(advance),
    .addr_bank(addr_bank), .addr_row(addr_row), .addr_col(addr_col),
    .addr_valid(addr_valid), .bank_change(bank_change), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected walk: nested loops, outermost to innermost, per R3-R9.
  task automatic build_walk();
    int lo[3], hi[3], ord[3], v[3];
    logic [AW-1:0] plain[$];
    lo[0] = 0; hi[0] = (1 << CW) - 1;
    lo[1] = 0; hi[1] = (1 << RW) - 1;
    lo[2] = 0; hi[2] = (1 << BW) - 1;
    if (cfg_range) begin
      lo[0] = sc; hi[0] = ec; lo[1] = sr; hi[1] = er; lo[2] = sb; hi[2] = eb;
    end
    if (cfg_mode < 2) begin
      lo[2] = cfg_range ? int'(sb) : 0;
      hi[2] = lo[2];
    end
    case (cfg_mode)
      2'd0: begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
      2'd1: begin ord[0] = 1; ord[1] = 0; ord[2] = 2; end
      2'd2: begin ord[0] = 0; ord[1] = 2; ord[2] = 1; end
      default: begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
    endcase
    for (int t2 = 0; t2 <= hi[ord[2]] - lo[ord[2]]; t2++)
      for (int t1 = 0; t1 <= hi[ord[1]] - lo[ord[1]]; t1++)
        for (int t0 = 0; t0 <= hi[ord[0]] - lo[ord[0]]; t0++) begin
          v[ord[2]] = cfg_down ? hi[ord[2]] - t2 : lo[ord[2]] + t2;
          v[ord[1]] = cfg_down ? hi[ord[1]] - t1 : lo[ord[1]] + t1;
          v[ord[0]] = cfg_down ? hi[ord[0]] - t0 : lo[ord[0]] + t0;
          plain.push_back({BW'(v[2]), RW'(v[1]), CW'(v[0])});
        end
    exp_q.delete(); bc_q.delete();
    for (int k = 0; k < plain.size(); k++) begin
      if (cfg_invert && k[0]) exp_q.push_back({~exp_q[k-1][AW-1:1], plain[k][0]});
      else                    exp_q.push_back(plain[k]);
      bc_q.push_back(k == 0 || exp_q[k][AW-1 -: BW] != exp_q[k-1][AW-1 -: BW]);
    end
  endtask

  // One cycle: compare at the falling edge, then drive and advance the model.
  task automatic tick(input bit st, input bit adv);
    @(negedge clk);
    chk(addr_valid == ev, "R1 R11 valid", addr_valid, ev);
    chk(done == ed, "R11 done", done, ed);
    if (ev) begin
      chk({addr_bank, addr_row, addr_col} == exp_q[idx],
          (cfg_invert && idx[0]) ? "R7 inverted address" : "R5 R6 R8 address",
          {addr_bank, addr_row, addr_col}, exp_q[idx]);
      chk(bank_change == bc_q[idx], "R10 bank_change", bank_change, bc_q[idx]);
    end else begin
      chk(bank_change == 1'b0, "R10 idle bank_change", bank_change, 0);
    end
    start = st; advance = adv;
    if (st) begin
      build_walk(); idx = 0; ev = 1; ed = 0;
    end else if (ev && adv) begin
      if (idx == exp_q.size() - 1) begin ev = 0; ed = 1; end
      else idx++;
    end
  endtask

  task automatic run(input int mode, input bit rng, input bit dn, input bit inv,
                     input int pct, input int max_cyc);
    cfg_mode = 2'(mode); cfg_range = rng; cfg_down = dn; cfg_invert = inv;
    tick(1, $urandom % 2);   // start wins over advance (R1)
    for (int n = 0; n < max_cyc && !ed; n++) tick(0, ($urandom % 100) < pct);
    tick(0, 1); tick(0, 0);  // done stays high (R11)
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    chk(addr_valid == 0, "R13 valid in reset", addr_valid, 0);
    chk(done == 0, "R13 done in reset", done, 0);
    @(negedge clk); rst_n = 1;
    tick(0, 1); tick(0, 0);

    // R3 R5: full, mode 0, up, no inversion (R8)
    run(0, 0, 0, 0, 70, 2000);
    // R4 R6 R7: range, mode 1, down, inverted; fixed bank = start bank
    sb = 2'd2; eb = 2'd3; sr = 3'd1; er = 3'd5; sc = 3'd2; ec = 3'd6;
    run(1, 1, 1, 1, 60, 2000);
    // R5 R7 R10: column-bank-row, range, up, inverted
    sb = 2'd1; eb = 2'd2; sr = 3'd3; er = 3'd4; sc = 3'd0; ec = 3'd3;
    run(2, 1, 0, 1, 50, 2000);
    // R3 R6: row-bank-column, full, down
    run(3, 0, 1, 0, 80, 4000);
    // R2 R12: stall-heavy walk abandoned mid-run, then restarted (R9)
    sb = 2'd0; eb = 2'd3; sr = 3'd0; er = 3'd2; sc = 3'd1; ec = 3'd4;
    cfg_mode = 2'd2; cfg_range = 1; cfg_down = 0; cfg_invert = 1;
    tick(1, 0);
    for (int n = 0; n < 25; n++) tick(0, ($urandom % 100) < 30);
    run(2, 1, 1, 1, 90, 2000);
    // R7 R10: full walk, mode 3, up, inverted
    run(3, 0, 0, 1, 100, 4000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule